// File: doc/BRIEF.md
# Multi-Codec Mixer Address Decoder

This block sits between a host access port and the codec link controller of an audio function. It watches each host access, decides whether it falls inside one of two programmed mixer register windows, and turns a hit into a codec register request. The I/O window is 256 bytes and reaches the primary and secondary codecs. The memory window is 512 bytes and reaches the primary, secondary and tertiary codecs, followed by a reserved quarter that answers reads with zero and drops writes.

Each request carries a codec select, a 7-bit register index that is always even, the read/write flag, the write data and the 2-bit codec ID for the outgoing frame's first slot. The ID is also shifted out serially, high bit first, over two cycles. After launching a request the block stays busy until the link controller reports completion. On completion of a read, the returned data is handed back to the host side. When the function's power state is D3hot, neither window decodes.

Top module: `codec_win_decoder`

## Requirements
- R1: An I/O access (acc_is_mem_i = 0) hits only when io_en_i is 1, address bits 31:16 are zero and address bits 15:8 equal io_base_i.
- R2: In the I/O window, offsets 00h-7Fh select the primary codec (code 0) and offsets 80h-FFh select the secondary codec (code 1). The tertiary codec (code 2) is never selected by an I/O access. The register index is the offset modulo 128 with bit 0 cleared.
- R3: A memory access (acc_is_mem_i = 1) hits only when mem_en_i is 1 and address bits 31:9 equal mem_base_i.
- R4: In the memory window, offsets 000h-07Fh select the primary codec (code 0), 080h-0FFh the secondary codec (code 1) and 100h-17Fh the tertiary codec (code 2). The index is the offset modulo 128 with bit 0 cleared.
- R5: A hit on memory offsets 180h-1FFh raises no request and does not set busy. A read there pulses rd_valid_o with rd_data_o = 0 one cycle after it is accepted. A write there produces no output at all.
- R6: The slot ID is 00b for the primary codec, codec_id_cfg_i[1:0] for the secondary codec and codec_id_cfg_i[3:2] for the tertiary codec. id_ser_valid_o is high for the cycle of req_o and the following cycle. id_ser_bit_o carries ID bit 1 in the first of these cycles and ID bit 0 in the second.
- R7: While pwr_state_i is 11b (D3hot), hit_o stays 0 and no access raises a request, whatever the enables are.
- R8: An accepted access to a codec region raises req_o for exactly one cycle, in the cycle after the access, with its fields valid. busy_o rises together with req_o and stays high until a cycle in which codec_done_i is sampled high. If the request was a read, rd_valid_o then pulses for one cycle with rd_data_o equal to codec_rdata_i.
- R9: An access that misses both windows raises no request and leaves busy_o unchanged. A hitting access presented while busy_o is high is dropped: it raises no request and no rd_valid_o. codec_done_i sampled while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_base_i | input | 8 | I/O window base, compared with address bits 15:8 |
| mem_base_i | input | 23 | Memory window base, compared with address bits 31:9 |
| io_en_i | input | 1 | I/O space decode enable |
| mem_en_i | input | 1 | Memory space decode enable |
| pwr_state_i | input | 2 | Power state; 11b is D3hot |
| codec_id_cfg_i | input | 4 | Bits 1:0 secondary ID, bits 3:2 tertiary ID |
| acc_valid_i | input | 1 | Host access present this cycle |
| acc_is_mem_i | input | 1 | 1 = memory access, 0 = I/O access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 32 | Access address |
| acc_wdata_i | input | 16 | Write data |
| codec_done_i | input | 1 | Codec transaction completed |
| codec_rdata_i | input | 16 | Read data returned by the codec |
| hit_o | output | 1 | Current access falls in an enabled window |
| req_o | output | 1 | One-cycle codec request strobe |
| req_codec_o | output | 2 | Target codec: 0 primary, 1 secondary, 2 tertiary |
| req_index_o | output | 7 | Codec register index, bit 0 always 0 |
| req_write_o | output | 1 | Request is a write |
| req_wdata_o | output | 16 | Request write data |
| req_slot_id_o | output | 2 | Codec ID for the frame's first slot |
| id_ser_valid_o | output | 1 | Serial ID bit is valid |
| id_ser_bit_o | output | 1 | Serial ID bit, bit 1 first |
| busy_o | output | 1 | A codec request is outstanding |
| rd_valid_o | output | 1 | Read data returned to the host |
| rd_data_o | output | 16 | Returned read data |

## Verification
I/O accesses are tried at the base, with a non-zero upper half-word, with a neighbouring base and with the enable off. These separate the base compare, the upper-zero rule and the enable. Memory accesses probe the last word of each quarter and the first word of the next, so an off-by-one in the region split shows up as a wrong codec code. They also probe an odd offset, which shows whether bit 0 of the index is cleared. The secondary and tertiary IDs are programmed to mirror-image values and later changed, so a swapped ID source or a reversed serial order gives a different bit stream. Back-to-back accesses while busy, stray completions, reserved-quarter reads and writes, and D3hot with both enables on show that dropped accesses leave no trace on the request, busy and read-return outputs.

// File: rtl/codec_win_pkg.sv
package codec_win_pkg;

   typedef enum logic [1:0] {
      CW_PRI = 2'd0,
      CW_SEC = 2'd1,
      CW_TER = 2'd2
   } cw_codec_e;

   localparam logic [1:0] CW_PWR_D3HOT = 2'b11;
   localparam int unsigned CW_ID_W = 2;

endpackage

// File: rtl/cw_window_decode.sv
module cw_window_decode
   import codec_win_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IO_SPACE_AW = 16,
   parameter int unsigned IDX_W       = 7,
   localparam int unsigned IO_WIN_AW  = IDX_W + 1,
   localparam int unsigned MEM_WIN_AW = IDX_W + 2,
   localparam int unsigned IO_BASE_W  = IO_SPACE_AW - IO_WIN_AW,
   localparam int unsigned MEM_BASE_W = ADDR_W - MEM_WIN_AW,
   localparam int unsigned REG_W      = MEM_WIN_AW - IDX_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic                      acc_is_mem,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic [IO_BASE_W-1:0]      io_base,
   input  logic [MEM_BASE_W-1:0]     mem_base,
   input  logic                      io_en,
   input  logic                      mem_en,
   input  logic [1:0]                pwr_state,
   input  logic [2*CW_ID_W-1:0]      codec_id_cfg,
   output logic                      hit,
   output logic                      rsvd,
   output cw_codec_e                 codec,
   output logic [IDX_W-1:0]          index,
   output logic [CW_ID_W-1:0]        slot_id
);

   logic             blocked;
   logic             io_hit;
   logic             mem_hit;
   logic [REG_W-1:0] region;

   assign blocked = (pwr_state == CW_PWR_D3HOT);

   assign io_hit  = io_en && !blocked && !acc_is_mem
                 && (acc_addr[ADDR_W-1:IO_SPACE_AW] == '0)
                 && (acc_addr[IO_SPACE_AW-1:IO_WIN_AW] == io_base);

   assign mem_hit = mem_en && !blocked && acc_is_mem
                 && (acc_addr[ADDR_W-1:MEM_WIN_AW] == mem_base);

   assign hit = acc_valid && (io_hit || mem_hit);

   // The I/O window has half the span, so its top region bit is zero.
   assign region = acc_is_mem ? acc_addr[MEM_WIN_AW-1:IDX_W]
                              : REG_W'(acc_addr[IO_WIN_AW-1:IDX_W]);

   assign rsvd  = hit && acc_is_mem && (region == '1);
   assign index = acc_addr[IDX_W-1:0] & ~IDX_W'(1);

   always_comb begin
      unique case (region)
         2'd1:    codec = CW_SEC;
         2'd2:    codec = CW_TER;
         default: codec = CW_PRI;
      endcase
   end

   always_comb begin
      unique case (codec)
         CW_SEC:  slot_id = codec_id_cfg[CW_ID_W-1:0];
         CW_TER:  slot_id = codec_id_cfg[2*CW_ID_W-1:CW_ID_W];
         default: slot_id = '0;
      endcase
   end

   assert_io_no_tertiary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !acc_is_mem) |-> (codec != CW_TER));

   assert_d3_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == CW_PWR_D3HOT) |-> !hit);

   assert_rsvd_only_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd |-> (acc_is_mem && hit));

endmodule

// File: rtl/cw_req_ctrl.sv
module cw_req_ctrl
   import codec_win_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_write,
   input  logic [DATA_W-1:0]   acc_wdata,
   input  logic                hit,
   input  logic                rsvd,
   input  cw_codec_e           codec,
   input  logic [IDX_W-1:0]    index,
   input  logic [CW_ID_W-1:0]  slot_id,
   input  logic                codec_done,
   input  logic [DATA_W-1:0]   codec_rdata,
   output logic                launch,
   output logic                req,
   output cw_codec_e           req_codec,
   output logic [IDX_W-1:0]    req_index,
   output logic                req_write,
   output logic [DATA_W-1:0]   req_wdata,
   output logic [CW_ID_W-1:0]  req_slot_id,
   output logic                busy,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data
);

   logic accept;
   logic pend_rd;
   logic finish;

   assign accept = hit && !busy;
   assign launch = accept && !rsvd;
   assign finish = busy && codec_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req         <= 1'b0;
         req_codec   <= CW_PRI;
         req_index   <= '0;
         req_write   <= 1'b0;
         req_wdata   <= '0;
         req_slot_id <= '0;
         busy        <= 1'b0;
         pend_rd     <= 1'b0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
      end else begin
         req <= launch;
         if (launch) begin
            req_codec   <= codec;
            req_index   <= index;
            req_write   <= acc_write;
            req_wdata   <= acc_wdata;
            req_slot_id <= slot_id;
            busy        <= 1'b1;
            pend_rd     <= !acc_write;
         end else if (finish) begin
            busy        <= 1'b0;
         end
         rd_valid <= (accept && rsvd && !acc_write) || (finish && pend_rd);
         rd_data  <= (finish && pend_rd) ? codec_rdata : '0;
      end
   end

   assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);

   assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> busy);

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !codec_done) |=> busy);

   assert_miss_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !busy) |=> (!busy && !req));

   assert_rsvd_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsvd && !busy) |=> (!req && !busy));

endmodule

// File: rtl/cw_id_shifter.sv
module cw_id_shifter
   import codec_win_pkg::*;
#(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [CW_ID_W-1:0] id,
   output logic               ser_valid,
   output logic               ser_bit
);

   localparam int unsigned CNT_W = $clog2(CW_ID_W + 1);

   logic [CW_ID_W-1:0] ordered;
   logic [CW_ID_W-1:0] shreg;
   logic [CNT_W-1:0]   left;

   generate
      if (MSB_FIRST) begin : g_msb
         assign ordered = id;
      end else begin : g_lsb
         for (genvar b = 0; b < CW_ID_W; b++) begin : g_rev
            assign ordered[b] = id[CW_ID_W-1-b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
      end else if (load) begin
         shreg <= ordered;
         left  <= CNT_W'(CW_ID_W);
      end else if (left != '0) begin
         shreg <= {shreg[CW_ID_W-2:0], 1'b0};
         left  <= left - 1'b1;
      end
   end

   assign ser_valid = (left != '0);
   assign ser_bit   = shreg[CW_ID_W-1];

   assert_ser_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ser_valid ##1 ser_valid);

endmodule

// File: rtl/codec_win_decoder.sv
module codec_win_decoder
   import codec_win_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned IO_SPACE_AW  = 16,
   parameter int unsigned IDX_W        = 7,
   parameter bit          ID_MSB_FIRST = 1'b1,
   localparam int unsigned IO_BASE_W   = IO_SPACE_AW - (IDX_W + 1),
   localparam int unsigned MEM_BASE_W  = ADDR_W - (IDX_W + 2)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IO_BASE_W-1:0]    io_base_i,
   input  logic [MEM_BASE_W-1:0]   mem_base_i,
   input  logic                    io_en_i,
   input  logic                    mem_en_i,
   input  logic [1:0]              pwr_state_i,
   input  logic [3:0]              codec_id_cfg_i,
   input  logic                    acc_valid_i,
   input  logic                    acc_is_mem_i,
   input  logic                    acc_write_i,
   input  logic [ADDR_W-1:0]       acc_addr_i,
   input  logic [DATA_W-1:0]       acc_wdata_i,
   input  logic                    codec_done_i,
   input  logic [DATA_W-1:0]       codec_rdata_i,
   output logic                    hit_o,
   output logic                    req_o,
   output logic [1:0]              req_codec_o,
   output logic [IDX_W-1:0]        req_index_o,
   output logic                    req_write_o,
   output logic [DATA_W-1:0]       req_wdata_o,
   output logic [1:0]              req_slot_id_o,
   output logic                    id_ser_valid_o,
   output logic                    id_ser_bit_o,
   output logic                    busy_o,
   output logic                    rd_valid_o,
   output logic [DATA_W-1:0]       rd_data_o
);

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("IDX_W must be at least 2");
      end
      if (IO_SPACE_AW <= IDX_W + 1 || IO_SPACE_AW >= ADDR_W) begin : g_bad_io
         $error("IO_SPACE_AW must lie between the I/O window and ADDR_W");
      end
      if (ADDR_W <= IDX_W + 2) begin : g_bad_addr
         $error("ADDR_W too small for the memory window");
      end
   endgenerate

   logic             dec_rsvd;
   cw_codec_e        dec_codec;
   logic [IDX_W-1:0] dec_index;
   logic [1:0]       dec_slot_id;
   logic             launch;
   cw_codec_e        req_codec;

   cw_window_decode #(
      .ADDR_W      (ADDR_W),
      .IO_SPACE_AW (IO_SPACE_AW),
      .IDX_W       (IDX_W)
   ) u_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid_i),
      .acc_is_mem   (acc_is_mem_i),
      .acc_addr     (acc_addr_i),
      .io_base      (io_base_i),
      .mem_base     (mem_base_i),
      .io_en        (io_en_i),
      .mem_en       (mem_en_i),
      .pwr_state    (pwr_state_i),
      .codec_id_cfg (codec_id_cfg_i),
      .hit          (hit_o),
      .rsvd         (dec_rsvd),
      .codec        (dec_codec),
      .index        (dec_index),
      .slot_id      (dec_slot_id)
   );

   cw_req_ctrl #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_write   (acc_write_i),
      .acc_wdata   (acc_wdata_i),
      .hit         (hit_o),
      .rsvd        (dec_rsvd),
      .codec       (dec_codec),
      .index       (dec_index),
      .slot_id     (dec_slot_id),
      .codec_done  (codec_done_i),
      .codec_rdata (codec_rdata_i),
      .launch      (launch),
      .req         (req_o),
      .req_codec   (req_codec),
      .req_index   (req_index_o),
      .req_write   (req_write_o),
      .req_wdata   (req_wdata_o),
      .req_slot_id (req_slot_id_o),
      .busy        (busy_o),
      .rd_valid    (rd_valid_o),
      .rd_data     (rd_data_o)
   );

   cw_id_shifter #(
      .MSB_FIRST (ID_MSB_FIRST)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (launch),
      .id        (dec_slot_id),
      .ser_valid (id_ser_valid_o),
      .ser_bit   (id_ser_bit_o)
   );

   assign req_codec_o = req_codec;

   assert_ser_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> id_ser_valid_o);

endmodule

// File: tb/codec_win_decoder_tb.sv
module codec_win_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_base = '0;
   logic [22:0] mem_base = '0;
   logic        io_en = 1'b0, mem_en = 1'b0;
   logic [1:0]  pwr = 2'b00;
   logic [3:0]  cfg = 4'h0;
   logic        acc_valid = 1'b0, acc_is_mem = 1'b0, acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [15:0] acc_wdata = '0;
   logic        codec_done = 1'b0;
   logic [15:0] codec_rdata = '0;

   logic        hit_o, req_o, req_write_o, id_ser_valid_o, id_ser_bit_o, busy_o, rd_valid_o;
   logic [1:0]  req_codec_o, req_slot_id_o;
   logic [6:0]  req_index_o;
   logic [15:0] req_wdata_o, rd_data_o;

   codec_win_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .io_base_i(io_base), .mem_base_i(mem_base),
      .io_en_i(io_en), .mem_en_i(mem_en), .pwr_state_i(pwr), .codec_id_cfg_i(cfg),
      .acc_valid_i(acc_valid), .acc_is_mem_i(acc_is_mem), .acc_write_i(acc_write),
      .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .codec_done_i(codec_done),
      .codec_rdata_i(codec_rdata), .hit_o(hit_o), .req_o(req_o), .req_codec_o(req_codec_o),
      .req_index_o(req_index_o), .req_write_o(req_write_o), .req_wdata_o(req_wdata_o),
      .req_slot_id_o(req_slot_id_o), .id_ser_valid_o(id_ser_valid_o),
      .id_ser_bit_o(id_ser_bit_o), .busy_o(busy_o), .rd_valid_o(rd_valid_o),
      .rd_data_o(rd_data_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done_flag = 1'b0;
   string tag = "R8";

   // reference model state
   int m_req = 0, m_codec = 0, m_idx = 0, m_wr = 0, m_wdata = 0, m_slot = 0;
   int m_busy = 0, m_pend = 0, m_rdv = 0, m_rdata = 0;
   int m_sv = 0, m_sbit = 0, m_left = 0, m_next = 0;
   bit m_lock = 1'b0;

   function automatic void ref_decode(output int h, output int rs, output int cod,
                                      output int idx, output int sid);
      int off;
      h = 0;
      if (acc_valid && pwr != 2'b11) begin
         if (acc_is_mem) h = (mem_en && acc_addr[31:9] == mem_base) ? 1 : 0;
         else h = (io_en && acc_addr[31:16] == 16'h0 && acc_addr[15:8] == io_base) ? 1 : 0;
      end
      off = acc_is_mem ? int'(acc_addr[8:0]) : int'(acc_addr[7:0]);
      cod = off / 128;
      rs  = (h == 1 && cod == 3) ? 1 : 0;
      idx = (off % 128) - (off % 2);
      sid = (cod == 1) ? int'(cfg) % 4 : (cod == 2) ? int'(cfg) / 4 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      int h, rs, cod, idx, sid, acc, fin;
      if (!rst_n) begin
         m_req = 0; m_busy = 0; m_pend = 0; m_rdv = 0; m_rdata = 0;
         m_sv = 0; m_left = 0; m_lock = 1'b1;
      end else begin
         ref_decode(h, rs, cod, idx, sid);
         acc = (h == 1 && m_busy == 0) ? 1 : 0;
         fin = (m_busy == 1 && codec_done) ? 1 : 0;
         // serial ID: high bit in the request cycle, low bit in the next
         if (acc == 1 && rs == 0) begin
            m_sv = 1; m_sbit = sid / 2; m_next = sid % 2; m_left = 1;
         end else if (m_left == 1) begin
            m_sv = 1; m_sbit = m_next; m_left = 0;
         end else m_sv = 0;
         m_rdv = 0; m_rdata = 0;
         if (acc == 1 && rs == 1 && !acc_write) m_rdv = 1;
         if (fin == 1 && m_pend == 1) begin m_rdv = 1; m_rdata = int'(codec_rdata); end
         m_req = (acc == 1 && rs == 0) ? 1 : 0;
         if (m_req == 1) begin
            m_codec = cod; m_idx = idx; m_wr = int'(acc_write);
            m_wdata = int'(acc_wdata); m_slot = sid; m_busy = 1; m_pend = acc_write ? 0 : 1;
         end else if (fin == 1) m_busy = 0;
      end
   end

   task automatic cmp(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   initial begin
      forever begin
         int h, rs, cod, idx, sid;
         @(negedge clk);
         #5;
         if (m_lock) begin
            ref_decode(h, rs, cod, idx, sid);
            cmp("hit_o", int'(hit_o), h);
            cmp("req_o", int'(req_o), m_req);
            cmp("busy_o", int'(busy_o), m_busy);
            cmp("rd_valid_o", int'(rd_valid_o), m_rdv);
            cmp("id_ser_valid_o", int'(id_ser_valid_o), m_sv);
            if (m_req == 1) begin
               cmp("req_codec_o", int'(req_codec_o), m_codec);
               cmp("req_index_o", int'(req_index_o), m_idx);
               cmp("req_write_o", int'(req_write_o), m_wr);
               cmp("req_wdata_o", int'(req_wdata_o), m_wdata);
               cmp("req_slot_id_o", int'(req_slot_id_o), m_slot);
            end
            if (m_sv == 1) cmp("id_ser_bit_o", int'(id_ser_bit_o), m_sbit);
            if (m_rdv == 1) cmp("rd_data_o", int'(rd_data_o), m_rdata);
         end
      end
   end

   task automatic access(bit mem, bit wr, logic [31:0] a, logic [15:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_is_mem = mem; acc_write = wr; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic finish_codec(logic [15:0] d);
      repeat (2) @(negedge clk);
      codec_done = 1'b1; codec_rdata = d;
      @(negedge clk);
      codec_done = 1'b0; codec_rdata = '0;
      @(negedge clk);
   endtask

   function automatic logic [31:0] maddr(int off);
      return {mem_base, 9'(off)};
   endfunction

   initial begin
      tag = "R8";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      io_base = 8'h12; mem_base = 23'h0A5A5A; io_en = 1'b1; mem_en = 1'b1;
      cfg = 4'b0110;   // secondary 10b, tertiary 01b
      // R1: I/O hit rule
      tag = "R1";
      access(1'b0, 1'b0, 32'h0000_1204, '0); finish_codec(16'hBEEF);
      access(1'b0, 1'b0, 32'h0001_1204, '0); finish_codec(16'h1111);
      access(1'b0, 1'b1, 32'h0000_1304, 16'h2222); finish_codec(16'h0);
      io_en = 1'b0;
      access(1'b0, 1'b0, 32'h0000_1208, '0); finish_codec(16'h3333);
      io_en = 1'b1;
      // R2: I/O region split and index
      tag = "R2";
      access(1'b0, 1'b1, 32'h0000_127F, 16'hA5A5); finish_codec(16'h0);
      access(1'b0, 1'b1, 32'h0000_1280, 16'h5A5A); finish_codec(16'h0);
      access(1'b0, 1'b0, 32'h0000_12FF, '0); finish_codec(16'hC0DE);
      // R3: memory hit rule
      tag = "R3";
      access(1'b1, 1'b0, maddr(16), '0); finish_codec(16'h4444);
      access(1'b1, 1'b0, {mem_base + 23'd1, 9'h010}, '0); finish_codec(16'h5555);
      access(1'b0, 1'b0, maddr(16), '0); finish_codec(16'h6666);
      mem_en = 1'b0;
      access(1'b1, 1'b0, maddr(16), '0); finish_codec(16'h7777);
      mem_en = 1'b1;
      // R4: memory region split
      tag = "R4";
      access(1'b1, 1'b0, maddr(9'h07E), '0); finish_codec(16'h0101);
      access(1'b1, 1'b1, maddr(9'h080), 16'h0202); finish_codec(16'h0);
      access(1'b1, 1'b0, maddr(9'h0FF), '0); finish_codec(16'h0303);
      access(1'b1, 1'b1, maddr(9'h100), 16'h0404); finish_codec(16'h0);
      access(1'b1, 1'b0, maddr(9'h17F), '0); finish_codec(16'h0505);
      // R5: reserved quarter
      tag = "R5";
      access(1'b1, 1'b0, maddr(9'h180), '0); finish_codec(16'h0606);
      access(1'b1, 1'b1, maddr(9'h1FF), 16'h0707); finish_codec(16'h0808);
      // R6: changed IDs, serial order
      tag = "R6";
      cfg = 4'b1001;
      access(1'b1, 1'b0, maddr(9'h0C2), '0); finish_codec(16'h0909);
      access(1'b1, 1'b0, maddr(9'h142), '0); finish_codec(16'h0A0A);
      access(1'b0, 1'b0, 32'h0000_1290, '0); finish_codec(16'h0B0B);
      cfg = 4'b1111;
      access(1'b1, 1'b1, maddr(9'h110), 16'h0C0C); finish_codec(16'h0);
      // R7: D3hot blocks both windows
      tag = "R7";
      pwr = 2'b11;
      access(1'b0, 1'b0, 32'h0000_1204, '0); finish_codec(16'h0D0D);
      access(1'b1, 1'b0, maddr(9'h100), '0); finish_codec(16'h0E0E);
      pwr = 2'b10;
      access(1'b1, 1'b0, maddr(9'h004), '0); finish_codec(16'h0F0F);
      pwr = 2'b00;
      // R9: accesses while busy and stray completions
      tag = "R9";
      access(1'b0, 1'b0, 32'h0000_1210, '0);
      access(1'b1, 1'b1, maddr(9'h120), 16'h1212);
      access(1'b1, 1'b0, maddr(9'h190), '0);
      finish_codec(16'h1313);
      @(negedge clk); codec_done = 1'b1; codec_rdata = 16'h9999;
      @(negedge clk); codec_done = 1'b0;
      access(1'b1, 1'b0, maddr(9'h0A0), '0);
      @(negedge clk); codec_done = 1'b1; codec_rdata = 16'hFACE;
      @(negedge clk); codec_done = 1'b0;
      repeat (3) @(negedge clk);
      // R8: mid-run reset returns outputs to idle
      tag = "R8";
      access(1'b0, 1'b0, 32'h0000_1220, '0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule